// File: doc/BRIEF.md
# Variable-Length Two-Address Memory-to-Memory Processor Core

The core runs programs held in a 256-byte external memory. It reaches that memory through a synchronous byte port, and every instruction works directly on memory. Each instruction starts with an opcode byte, and the opcode's class sets the instruction length: three bytes (opcode, first address, second address) for arithmetic, compare and move; two bytes (opcode, target address) for jumps; one byte for halt. Data operands are 32-bit words stored most-significant byte first at the addressed location. The core reads them one byte per cycle into two operand registers.

Results are written back, MSB first, to the first address. Compare writes nothing to memory. It only updates an internal flag set (zero, sign, borrow, overflow), and the conditional jumps that follow test those flags. Any opcode byte outside the legal set stops the core with an error. A divide by zero does the same. A halt opcode stops it cleanly. In both stopped conditions the core stays idle until reset.

A pulse on the start input begins execution at address 0. The program counter is visible on an output port so that its final value can be observed.

Top module: `vlc_core`

## Requirements
- R1: After reset, running_o, halted_o, error_o and mem_we_o are 0 and pc_o is 0. The core stays in this state until start_i is sampled high. At most one of running_o, halted_o and error_o is high at any time.
- R2: The program counter advances by the instruction length: 3 for opcodes 0x00-0x05, 0x13 and 0x14; 2 for 0x80-0x86 and 0x93-0x96; 1 for 0x99.
- R3: Any opcode outside {0x00-0x05, 0x13, 0x14, 0x80-0x86, 0x93-0x96, 0x99} raises error_o and stops execution, with pc_o one past the bad byte. error_o stays high until reset.
- R4: Opcode 0x01 stores (word[A1] + word[A2]) mod 2^32 at A1, and 0x02 stores word[A1] - word[A2] there. Words are big-endian: byte A1 holds bits 31:24 and byte A1+3 holds bits 7:0. The word at A2 is not changed.
- R5: Opcodes 0x03 (signed) and 0x13 (unsigned) store the low 32 bits of word[A1] * word[A2] at A1.
- R6: Opcodes 0x04 (signed) and 0x14 (unsigned) store the quotient at A1 and the remainder at A1+4. The signed quotient truncates toward zero, and the signed remainder takes the sign of the dividend.
- R7: A divide whose divisor word is zero raises error_o and leaves memory unchanged.
- R8: Opcode 0x00 copies the word at A2 to A1.
- R9: Opcode 0x05 changes no memory. It sets the flags from word[A1] - word[A2]: zero, sign, unsigned borrow and signed overflow.
- R10: Opcode 0x80 always loads pc with A1. The other jumps load pc with A1 only when their condition on the latest compare holds: 0x81 equal, 0x82 not equal, 0x83/0x84/0x85/0x86 signed less / greater-or-equal / less-or-equal / greater, and 0x93/0x94/0x95/0x96 the same four conditions unsigned.
- R11: Opcode 0x99 sets halted_o with pc one past the halt byte. The core then stays halted with pc unchanged, and start_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin execution from address 0 |
| mem_addr_o | output | 8 | Memory byte address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the address |
| running_o | output | 1 | Core is executing |
| halted_o | output | 1 | Halt opcode reached |
| error_o | output | 1 | Illegal opcode or divide by zero |
| pc_o | output | 8 | Program counter |

## Verification
Results only become final when a whole program ends. Each fetch or load byte takes two cycles, and each write-back byte takes one. The bench therefore does not sample at fixed cycle offsets. It samples on falling edges until running_o drops, and only then compares pc_o, the status outputs and the memory image. The core stops at most a few dozen cycles after the last instruction issues. Flags cannot be seen at the ports, so compare results are checked through the pc value left by a following conditional jump.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  typedef enum logic [2:0] {CL_MOVE, CL_ARITH, CL_CMP, CL_JUMP, CL_HALT, CL_BAD} op_class_e;

  typedef enum logic [3:0] {
    S_IDLE, S_FOP, S_FOPW, S_FARG, S_FARGW, S_RD, S_RDW, S_EXEC, S_WR, S_HALT, S_ERR
  } state_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/vlc_decode.sv
module vlc_decode
  import vlc_pkg::*;
(
  input  logic [7:0] op_i,
  output op_class_e  cls_o,
  output logic [1:0] nargs_o,
  output logic       legal_o
);
  always_comb begin
    unique case (op_i)
      8'h00:                                   cls_o = CL_MOVE;
      8'h01, 8'h02, 8'h03, 8'h04, 8'h13, 8'h14: cls_o = CL_ARITH;
      8'h05:                                   cls_o = CL_CMP;
      8'h80, 8'h81, 8'h82, 8'h83, 8'h84, 8'h85, 8'h86,
      8'h93, 8'h94, 8'h95, 8'h96:              cls_o = CL_JUMP;
      8'h99:                                   cls_o = CL_HALT;
      default:                                 cls_o = CL_BAD;
    endcase
    legal_o = (cls_o != CL_BAD);
    unique case (cls_o)
      CL_MOVE, CL_ARITH, CL_CMP: nargs_o = 2'd2;
      CL_JUMP:                   nargs_o = 2'd1;
      default:                   nargs_o = 2'd0;
    endcase
  end
endmodule

// File: rtl/vlc_alu.sv
module vlc_alu
  import vlc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [7:0]   op_i,
  input  logic [W-1:0] r1_i,
  input  logic [W-1:0] r2_i,
  input  flags_t       flags_i,
  output logic [W-1:0] res_o,
  output logic [W-1:0] rem_o,
  output logic         is_div_o,
  output logic         div_err_o,
  output flags_t       flags_o,
  output logic         take_o
);
  logic [W:0]          diff;
  logic [W-1:0]        r2_safe;
  logic signed [W-1:0] sq, sr;
  logic                lt_s, lt_u;

  always_comb begin
    diff       = {1'b0, r1_i} - {1'b0, r2_i};
    flags_o.z  = (diff[W-1:0] == '0);
    flags_o.n  = diff[W-1];
    flags_o.c  = diff[W];
    flags_o.v  = (r1_i[W-1] != r2_i[W-1]) && (diff[W-1] != r1_i[W-1]);

    is_div_o   = (op_i == 8'h04) || (op_i == 8'h14);
    div_err_o  = is_div_o && (r2_i == '0);
    r2_safe    = (r2_i == '0) ? W'(1) : r2_i;
    sq         = $signed(r1_i) / $signed(r2_safe);
    sr         = $signed(r1_i) % $signed(r2_safe);

    rem_o = '0;
    unique case (op_i)
      8'h01:        res_o = r1_i + r2_i;
      8'h02:        res_o = r1_i - r2_i;
      8'h03, 8'h13: res_o = W'(r1_i * r2_i);  // low word is sign-agnostic
      8'h04:        begin res_o = sq; rem_o = sr; end
      8'h14:        begin res_o = r1_i / r2_safe; rem_o = r1_i % r2_safe; end
      default:      res_o = r1_i;             // move
    endcase

    lt_s = flags_i.n ^ flags_i.v;
    lt_u = flags_i.c;
    unique case (op_i)
      8'h80:   take_o = 1'b1;
      8'h81:   take_o = flags_i.z;
      8'h82:   take_o = !flags_i.z;
      8'h83:   take_o = lt_s;
      8'h84:   take_o = !lt_s;
      8'h85:   take_o = lt_s || flags_i.z;
      8'h86:   take_o = !(lt_s || flags_i.z);
      8'h93:   take_o = lt_u;
      8'h94:   take_o = !lt_u;
      8'h95:   take_o = lt_u || flags_i.z;
      8'h96:   take_o = !(lt_u || flags_i.z);
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/vlc_core.sv
module vlc_core
  import vlc_pkg::*;
#(
  parameter int AW = 8,
  parameter int W  = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          running_o,
  output logic          halted_o,
  output logic          error_o,
  output logic [AW-1:0] pc_o
);
  localparam int NB = W / 8;
  localparam int IW = $clog2(2 * NB);

  state_e          state_q;
  logic [AW-1:0]   pc_q, a1_q, a2_q;
  logic [7:0]      opc_q;
  logic [W-1:0]    r1_q, r2_q;
  logic [2*W-1:0]  wb_q;
  logic [IW-1:0]   idx_q, wb_last_q;
  logic            argn_q, ld_q;
  flags_t          flags_q, flags_d;

  logic [7:0]      dec_op;
  op_class_e       cls;
  logic [1:0]      nargs;
  logic            legal;
  logic [W-1:0]    res, rem;
  logic            is_div, div_err, take;

  // decode the incoming byte during opcode capture, the held opcode otherwise
  assign dec_op = (state_q == S_FOPW) ? mem_rdata_i : opc_q;

  vlc_decode u_dec (.op_i(dec_op), .cls_o(cls), .nargs_o(nargs), .legal_o(legal));

  vlc_alu #(.W(W)) u_alu (
    .op_i(opc_q), .r1_i(r1_q), .r2_i(r2_q), .flags_i(flags_q),
    .res_o(res), .rem_o(rem), .is_div_o(is_div), .div_err_o(div_err),
    .flags_o(flags_d), .take_o(take)
  );

  always_comb begin
    unique case (state_q)
      S_RD:    mem_addr_o = ((ld_q || cls == CL_MOVE) ? a2_q : a1_q) + AW'(idx_q);
      S_WR:    mem_addr_o = a1_q + AW'(idx_q);
      default: mem_addr_o = pc_q;
    endcase
  end

  assign mem_we_o    = (state_q == S_WR);
  assign mem_wdata_o = wb_q[2*W-1 -: 8];
  assign running_o   = !(state_q inside {S_IDLE, S_HALT, S_ERR});
  assign halted_o    = (state_q == S_HALT);
  assign error_o     = (state_q == S_ERR);
  assign pc_o        = pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      pc_q      <= '0;
      a1_q      <= '0;
      a2_q      <= '0;
      opc_q     <= '0;
      r1_q      <= '0;
      r2_q      <= '0;
      wb_q      <= '0;
      idx_q     <= '0;
      wb_last_q <= '0;
      argn_q    <= 1'b0;
      ld_q      <= 1'b0;
      flags_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) state_q <= S_FOP;
        S_FOP:  state_q <= S_FOPW;
        S_FOPW: begin
          opc_q  <= mem_rdata_i;
          pc_q   <= pc_q + 1'b1;
          argn_q <= 1'b0;
          if (!legal)            state_q <= S_ERR;
          else if (nargs == 2'd0) state_q <= S_HALT;
          else                    state_q <= S_FARG;
        end
        S_FARG: state_q <= S_FARGW;
        S_FARGW: begin
          pc_q <= pc_q + 1'b1;
          if (!argn_q) begin
            a1_q <= mem_rdata_i;
            if (nargs == 2'd2) begin
              argn_q  <= 1'b1;
              state_q <= S_FARG;
            end else begin
              state_q <= S_EXEC;
            end
          end else begin
            a2_q    <= mem_rdata_i;
            idx_q   <= '0;
            ld_q    <= 1'b0;
            state_q <= S_RD;
          end
        end
        S_RD: state_q <= S_RDW;
        S_RDW: begin
          if (ld_q) r2_q <= {r2_q[W-9:0], mem_rdata_i};
          else      r1_q <= {r1_q[W-9:0], mem_rdata_i};
          if (idx_q == IW'(NB - 1)) begin
            idx_q <= '0;
            if (!ld_q && cls != CL_MOVE) begin
              ld_q    <= 1'b1;
              state_q <= S_RD;
            end else begin
              state_q <= S_EXEC;
            end
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_RD;
          end
        end
        S_EXEC: begin
          idx_q <= '0;
          unique case (cls)
            CL_CMP: begin
              flags_q <= flags_d;
              state_q <= S_FOP;
            end
            CL_JUMP: begin
              if (take) pc_q <= a1_q;
              state_q <= S_FOP;
            end
            default: begin
              if (div_err) begin
                state_q <= S_ERR;
              end else begin
                wb_q      <= {res, rem};
                wb_last_q <= is_div ? IW'(2 * NB - 1) : IW'(NB - 1);
                state_q   <= S_WR;
              end
            end
          endcase
        end
        S_WR: begin
          wb_q  <= wb_q << 8;
          idx_q <= idx_q + 1'b1;
          if (idx_q == wb_last_q) state_q <= S_FOP;
        end
        default: state_q <= state_q;  // S_HALT, S_ERR: idle until reset
      endcase
    end
  end

  AST_STATUS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({running_o, halted_o, error_o})); // R1
  AST_NO_WRITE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o |-> !mem_we_o); // R1
  AST_ILLEGAL_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FOPW && !legal) |=> error_o); // R3
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> error_o && !mem_we_o); // R3
  AST_DIV0_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_EXEC && div_err) |=> error_o); // R7
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && $stable(pc_o)); // R11
endmodule

// File: tb/vlc_core_bench.sv
module vlc_core_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] mem_addr_o, mem_wdata_o, pc_o;
  logic [7:0] mem_rdata_i = 8'h00;
  logic       mem_we_o, running_o, halted_o, error_o;

  logic [7:0] mem [256];
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    mem_rdata_i <= mem[mem_addr_o];
    cyc <= cyc + 1;
  end

  vlc_core u_vlc_core (
    .clk_i, .rst_ni, .start_i, .mem_addr_o, .mem_we_o, .mem_wdata_o,
    .mem_rdata_i, .running_o, .halted_o, .error_o, .pc_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic put_word(input int a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[(a + i) % 256] = v[31 - 8*i -: 8];
  endtask

  function automatic logic [31:0] get_word(input int a);
    return {mem[a % 256], mem[(a + 1) % 256], mem[(a + 2) % 256], mem[(a + 3) % 256]};
  endfunction

  // reset is held while the bench loads memory; then start and wait for stop
  task automatic run();
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    for (int n = 0; n < 4000 && running_o; n++) @(negedge clk_i);
  endtask

  task automatic hold_reset();
    @(negedge clk_i) rst_ni = 1'b0;
    clear_mem();
  endtask

  function automatic string req_of(input logic [7:0] op);
    case (op)
      8'h01, 8'h02: return "R4";
      8'h03, 8'h13: return "R5";
      8'h04, 8'h14: return "R6";
      8'h00:        return "R8";
      8'h05:        return "R9";
      default:      return "R10";
    endcase
  endfunction

  // {opcode, word at 0x10, word at 0x14, expected 0x10, expected 0x14, expected pc}
  localparam int NV = 21;
  localparam logic [143:0] VEC [NV] = '{
    {8'h01, 32'd12,         32'd10,         32'd22,         32'd10,         8'h04},
    {8'h02, 32'd5,          32'd7,          32'hFFFFFFFE,   32'd7,          8'h04},
    {8'h03, 32'hFFFFFFFD,   32'd7,          32'hFFFFFFEB,   32'd7,          8'h04},
    {8'h13, 32'h00010000,   32'h00010003,   32'h00030000,   32'h00010003,   8'h04},
    {8'h04, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFD,   32'hFFFFFFFF,   8'h04},
    {8'h14, 32'hFFFFFFF9,   32'd2,          32'h7FFFFFFC,   32'd1,          8'h04},
    {8'h04, 32'd7,          32'hFFFFFFFE,   32'hFFFFFFFD,   32'd1,          8'h04},
    {8'h05, 32'd3,          32'd9,          32'd3,          32'd9,          8'h04},
    {8'h00, 32'd1,          32'hCAFEF00D,   32'hCAFEF00D,   32'hCAFEF00D,   8'h04},
    {8'h81, 32'd5,          32'd5,          32'd5,          32'd5,          8'h0B},
    {8'h82, 32'd5,          32'd5,          32'd5,          32'd5,          8'h06},
    {8'h83, 32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF,   32'd1,          8'h0B},
    {8'h93, 32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF,   32'd1,          8'h06},
    {8'h84, 32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF,   32'd1,          8'h06},
    {8'h94, 32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF,   32'd1,          8'h0B},
    {8'h85, 32'd5,          32'd5,          32'd5,          32'd5,          8'h0B},
    {8'h86, 32'd5,          32'd5,          32'd5,          32'd5,          8'h06},
    {8'h95, 32'd2,          32'd3,          32'd2,          32'd3,          8'h0B},
    {8'h96, 32'd2,          32'd3,          32'd2,          32'd3,          8'h06},
    {8'h86, 32'h80000000,   32'd1,          32'h80000000,   32'd1,          8'h06},
    {8'h80, 32'd1,          32'd2,          32'd1,          32'd2,          8'h0B}
  };

  initial begin : watchdog
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    clear_mem();
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 running", running_o, 0);
    chk("R1 halted", halted_o, 0);
    chk("R1 error", error_o, 0);
    chk("R1 pc", pc_o, 0);
    chk("R1 we", mem_we_o, 0);
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk("R1 idle without start", {running_o, halted_o, error_o, pc_o}, 0);

    for (int k = 0; k < NV; k++) begin
      logic [7:0]  op;
      logic [31:0] a, b, e1, e2;
      logic [7:0]  epc;
      {op, a, b, e1, e2, epc} = VEC[k];
      hold_reset();
      put_word(8'h10, a);
      put_word(8'h14, b);
      if (op >= 8'h80) begin
        mem[0] = 8'h05; mem[1] = 8'h10; mem[2] = 8'h14;
        mem[3] = op;    mem[4] = 8'h0A;
        mem[5] = 8'h99; mem[8'h0A] = 8'h99;
      end else begin
        mem[0] = op; mem[1] = 8'h10; mem[2] = 8'h14; mem[3] = 8'h99;
      end
      run();
      chk({req_of(op), " pc (R2)"}, pc_o, epc);
      chk({req_of(op), " halted (R11)"}, halted_o, 1);
      chk({req_of(op), " word A1"}, get_word(8'h10), e1);
      chk({req_of(op), " word A1+4"}, get_word(8'h14), e2);
    end

    // R4: byte order of the written word
    hold_reset();
    mem[0] = 8'h01; mem[1] = 8'h10; mem[2] = 8'h14; mem[3] = 8'h99;
    put_word(8'h10, 32'h01020300); put_word(8'h14, 32'h00000004);
    run();
    chk("R4 msb byte", mem[8'h10], 8'h01);
    chk("R4 lsb byte", mem[8'h13], 8'h04);

    // R11 / R2: lone halt
    hold_reset();
    mem[0] = 8'h99;
    run();
    chk("R11 halted", halted_o, 1);
    chk("R11 pc", pc_o, 8'h01);
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk("R11 start ignored status", {running_o, halted_o, error_o}, 3'b010);
    chk("R11 start ignored pc", pc_o, 8'h01);

    // R3: illegal opcode first
    hold_reset();
    mem[0] = 8'h07;
    run();
    chk("R3 error", error_o, 1);
    chk("R3 not halted", halted_o, 0);
    chk("R3 pc", pc_o, 8'h01);
    repeat (4) @(negedge clk_i);
    chk("R3 sticky", error_o, 1);

    // R3: illegal opcode after a legal add
    hold_reset();
    mem[0] = 8'h01; mem[1] = 8'h10; mem[2] = 8'h14; mem[3] = 8'hFF;
    put_word(8'h10, 32'd1); put_word(8'h14, 32'd1);
    run();
    chk("R3 error late", error_o, 1);
    chk("R3 pc late", pc_o, 8'h04);
    chk("R3 add before trap", get_word(8'h10), 32'd2);

    // R7: divide by zero
    hold_reset();
    mem[0] = 8'h04; mem[1] = 8'h10; mem[2] = 8'h14; mem[3] = 8'h99;
    put_word(8'h10, 32'd9); put_word(8'h14, 32'd0);
    run();
    chk("R7 error", error_o, 1);
    chk("R7 dividend kept", get_word(8'h10), 32'd9);
    chk("R7 divisor kept", get_word(8'h14), 32'd0);

    // R10: countdown loop with a backward jump
    hold_reset();
    mem[0] = 8'h02; mem[1] = 8'h20; mem[2] = 8'h24;
    mem[3] = 8'h05; mem[4] = 8'h20; mem[5] = 8'h28;
    mem[6] = 8'h82; mem[7] = 8'h00;
    mem[8] = 8'h99;
    put_word(8'h20, 32'd3); put_word(8'h24, 32'd1); put_word(8'h28, 32'd0);
    run();
    chk("R10 loop counter", get_word(8'h20), 32'd0);
    chk("R10 loop pc", pc_o, 8'h09);
    chk("R10 loop halted", halted_o, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule